// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits between a serial deframer and a receive FIFO. The deframer delivers one byte per valid cycle. A start marker flags the first byte of a frame and an end marker flags the last. The first byte of every frame is its address. When filtering is on, that byte is compared with an 8-bit programmed value, and the frame is either forwarded byte for byte to the FIFO write port or abandoned.

An address of all ones is a broadcast and always passes. A mismatch ends the frame at once: a one-cycle drop pulse is raised and every later byte is ignored until the next start marker. This is the receiver's return to preamble hunt. The filter settings are captured only on the start byte, so software may reprogram them while a frame is in flight. If the FIFO is full when a forwarded byte arrives, that byte is lost and a sticky overflow flag records it until software clears it.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `push_valid`, `frame_drop` and `ovf_flag` are 0.
- R2: With `cfg_match_en` = 0, every byte of every frame is pushed, whatever its address.
- R3: With `cfg_match_en` = 1 and an address byte equal to `cfg_match_val`, the address byte, the control byte (second byte) and all data bytes are pushed in arrival order. Each appears on `push_data` with `push_valid` = 1 in the cycle after it is presented.
- R4: With `cfg_match_en` = 1 and an address that neither equals `cfg_match_val` nor is 0xFF, no byte of that frame is pushed.
- R5: With `cfg_match_en` = 1, an address of 0xFF is accepted for any `cfg_match_val`.
- R6: While `cfg_rx_en` = 0, the cycle after any input shows `push_valid` = 0 and `frame_drop` = 0.
- R7: `cfg_match_en` and `cfg_match_val` are taken only on the start byte. A change later in the frame does not alter whether that frame is kept or dropped.
- R8: A rejected frame raises `frame_drop` for exactly one cycle, in the cycle after its address byte. This holds for a single-byte frame too (start and end marked together).
- R9: A byte that would be pushed while `fifo_full` = 1 is not pushed, and `ovf_flag` becomes 1 in the next cycle and stays 1.
- R10: A cycle with `ovf_clr` = 1 clears `ovf_flag` in the next cycle, unless a new overflow occurs in that same cycle.
- R11: After an end-marked byte, bytes without a start marker are not pushed, whether the previous frame was kept or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_match_en | input | 1 | Address filtering enable |
| cfg_match_val | input | 8 | Programmed station address |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Byte is first of a frame (address) |
| in_eof | input | 1 | Byte is last of a frame |
| in_data | input | 8 | Input byte |
| fifo_full | input | 1 | FIFO cannot take a byte this cycle |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| push_valid | output | 1 | FIFO write strobe |
| push_data | output | 8 | FIFO write data |
| frame_drop | output | 1 | One-cycle pulse per rejected frame |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest case to reach is a configuration change inside a frame. The decision must stay tied to the value seen on the start byte. The stimulus gets there by sending a start byte with a matching address and then, on the cycle that drives the control byte, swapping both the match value and the enable. A second pass repeats this on a rejected frame, which must stay rejected. An overflow is produced by raising the full signal on one data byte in the middle of an accepted frame. The scoreboard then expects every other byte of that frame and no more.

// File: rtl/rx_flt_pkg.sv
package rx_flt_pkg;
    localparam int FLT_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PASS = 2'd1,
        ST_SKIP = 2'd2
    } flt_state_e;
endpackage

// File: rtl/flt_addr_match.sv
module flt_addr_match #(
    parameter int W = 8
) (
    input  logic         match_en,
    input  logic [W-1:0] match_val,
    input  logic [W-1:0] addr,
    output logic         accept
);
    localparam logic [W-1:0] BCAST = {W{1'b1}};

    always_comb begin
        accept = !match_en || (addr == match_val) || (addr == BCAST);
    end
endmodule

// File: rtl/flt_sticky_flag.sv
module flt_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);
    assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_flt_pkg::*;
#(
    parameter int DATA_W = FLT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_match_en,
    input  logic [DATA_W-1:0] cfg_match_val,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fifo_full,
    input  logic              ovf_clr,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              frame_drop,
    output logic              ovf_flag
);
    typedef struct packed {
        flt_state_e        state;
        logic              push_valid;
        logic [DATA_W-1:0] push_data;
        logic              drop;
    } flt_regs_t;

    flt_regs_t r_d, r_q;
    logic      addr_ok;
    logic      want_push;
    logic      ovf_set;

    flt_addr_match #(.W(DATA_W)) u_match (
        .match_en  (cfg_match_en),
        .match_val (cfg_match_val),
        .addr      (in_data),
        .accept    (addr_ok)
    );

    always_comb begin
        r_d            = r_q;
        r_d.push_valid = 1'b0;
        r_d.drop       = 1'b0;
        want_push      = 1'b0;
        if (!cfg_rx_en) begin
            r_d.state = ST_HUNT;
        end else if (in_valid) begin
            if (in_sof) begin
                if (addr_ok) begin
                    want_push = 1'b1;
                    r_d.state = in_eof ? ST_HUNT : ST_PASS;
                end else begin
                    r_d.drop  = 1'b1;
                    r_d.state = in_eof ? ST_HUNT : ST_SKIP;
                end
            end else begin
                case (r_q.state)
                    ST_PASS: begin
                        want_push = 1'b1;
                        if (in_eof) r_d.state = ST_HUNT;
                    end
                    ST_SKIP: begin
                        if (in_eof) r_d.state = ST_HUNT;
                    end
                    default: ;
                endcase
            end
        end
        if (want_push && !fifo_full) begin
            r_d.push_valid = 1'b1;
            r_d.push_data  = in_data;
        end
        ovf_set = want_push && fifo_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_HUNT, push_valid: 1'b0, push_data: '0, drop: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    flt_sticky_flag u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovf_set),
        .clr   (ovf_clr),
        .flag  (ovf_flag)
    );

    assign push_valid = r_q.push_valid;
    assign push_data  = r_q.push_data;
    assign frame_drop = r_q.drop;

    assert_rx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |=> (!push_valid && !frame_drop));
    assert_full_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !push_valid);
    assert_drop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> $past(in_valid && in_sof));
    assert_drop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !push_valid);
    assert_no_idle_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !push_valid);
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rx_en = 1'b0, cfg_match_en = 1'b0;
    logic [7:0] cfg_match_val = 8'h00;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       fifo_full = 1'b0, ovf_clr = 1'b0;
    logic       push_valid, frame_drop, ovf_flag;
    logic [7:0] push_data;

    int n_tests = 0, n_fail = 0;
    int exp_drops = 0, obs_drops = 0;
    bit prev_drop = 1'b0;
    string cur_req = "R1";
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_match_en(cfg_match_en),
        .cfg_match_val(cfg_match_val), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .fifo_full(fifo_full), .ovf_clr(ovf_clr),
        .push_valid(push_valid), .push_data(push_data), .frame_drop(frame_drop),
        .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares pushes against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (push_valid) begin
                if (exp_q.size() == 0) check({cur_req, " unexpected push"}, push_data, 0 + 9'h100);
                else check({cur_req, " push data"}, push_data, exp_q.pop_front());
            end
            if (frame_drop) begin
                obs_drops++;
                check("R8 single-cycle drop", prev_drop, 0);
            end
            prev_drop = frame_drop;
        end
    end

    task automatic drive(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; fifo_full = 1'b0; ovf_clr = 1'b0;
        end
    endtask

    // Driver: models the expected outcome and fills the scoreboard
    task automatic send_frame(input logic [7:0] addr, input int len, input int full_idx,
                              input bit flip);
        bit keep;
        keep = cfg_rx_en && (!cfg_match_en || addr == cfg_match_val || addr == 8'hFF);
        if (cfg_rx_en && !keep) exp_drops++;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = (i == 0) ? addr : 8'(i * 16 + 3);
            if (keep && i != full_idx) exp_q.push_back(b);
            drive(b, i == 0, i == len - 1);
            fifo_full = (i == full_idx);
            if (flip && i == 1) begin
                cfg_match_en  = ~cfg_match_en;
                cfg_match_val = ~cfg_match_val;
            end
        end
        idle(3);
    endtask

    task automatic settle(input string req);
        check({req, " scoreboard drained"}, exp_q.size(), 0);
        check({req, " drop count"}, obs_drops, exp_drops);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 push_valid", push_valid, 0);
        check("R1 frame_drop", frame_drop, 0);
        check("R1 ovf_flag", ovf_flag, 0);

        cfg_rx_en = 1'b1;
        cur_req = "R2"; cfg_match_en = 1'b0; cfg_match_val = 8'h5A;
        send_frame(8'h33, 4, -1, 1'b0);
        send_frame(8'h00, 2, -1, 1'b0);
        settle("R2");

        cur_req = "R3"; cfg_match_en = 1'b1;
        send_frame(8'h5A, 5, -1, 1'b0);
        settle("R3");

        cur_req = "R4";
        send_frame(8'h12, 4, -1, 1'b0);
        settle("R4");

        cur_req = "R11";
        drive(8'h77, 1'b0, 1'b0); drive(8'h78, 1'b0, 1'b0); idle(3);
        send_frame(8'h5A, 3, -1, 1'b0);
        drive(8'h79, 1'b0, 1'b0); drive(8'h7A, 1'b0, 1'b1); idle(3);
        settle("R11");

        cur_req = "R5";
        send_frame(8'hFF, 3, -1, 1'b0);
        cfg_match_val = 8'h00;
        send_frame(8'hFF, 2, -1, 1'b0);
        cfg_match_val = 8'h5A;
        settle("R5");

        cur_req = "R7";
        send_frame(8'h5A, 5, -1, 1'b1);
        cfg_match_en = 1'b1; cfg_match_val = 8'h5A;
        send_frame(8'h21, 5, -1, 1'b1);
        cfg_match_en = 1'b1; cfg_match_val = 8'h5A;
        settle("R7");

        cur_req = "R8";
        send_frame(8'h44, 1, -1, 1'b0);
        send_frame(8'h45, 1, -1, 1'b0);
        settle("R8");

        cur_req = "R6"; cfg_rx_en = 1'b0;
        send_frame(8'h5A, 3, -1, 1'b0);
        send_frame(8'h13, 3, -1, 1'b0);
        cfg_rx_en = 1'b1;
        settle("R6");

        cur_req = "R9";
        send_frame(8'h5A, 5, 2, 1'b0);
        settle("R9");
        check("R9 ovf set", ovf_flag, 1);
        idle(4);
        check("R9 ovf sticky", ovf_flag, 1);

        cur_req = "R10";
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R10 ovf cleared", ovf_flag, 0);
        idle(2);
        check("R10 stays clear", ovf_flag, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule